// File: doc/BRIEF.md
# Recursive Multiplier-Free Squarer

This block returns the full-width square of an unsigned operand without any multiplier. It rests on the identity A² = (A + C)·B + C². Here B = 2^(n-1) is the weight of the operand's top bit, and C is the operand with that top bit removed. Multiplying by B is only a left shift by n-1 places. The C² term is the square of a one-bit-narrower operand, formed the same way, so the unit is a chain of identical levels. The chain ends in a 2-bit leaf made of a single AND gate and a half adder.

When the top bit of an n-bit operand is set, the level forms (A + C), shifts it left by n-1 places, and adds the zero-extended square of the narrower operand. When the top bit is clear, the shifted term is forced to zero and the level passes the narrower square through. The result can go straight out, or through an output register that clears on a synchronous active-low reset. The register is on by default.

Top module: `rec_squarer`

## Requirements
- R1: With the output register enabled, `sq` equals `opnd` × `opnd` as a 2·WIDTH-bit unsigned value one clock edge after `opnd` is sampled, for every operand value.
- R2: A clock edge with `rst_n` low clears `sq` to zero, whatever value `opnd` has.
- R3: `sq` never exceeds (2^WIDTH − 1)², and the all-ones operand gives exactly that value (65025 for WIDTH = 8).
- R4: Bit 0 of `sq` equals bit 0 of the operand, and bit 1 of `sq` is always 0.
- R5: For operands 0, 1, 2 and 3, the low four bits of `sq` are 0, 1, 4 and 9 and all higher bits are 0. These are the values of the AND/half-adder leaf.
- R6: When the operand's top bit is clear, the two top bits of `sq` are 0 and `sq` equals the square of the operand with its top bit removed.
- R7: When the operand's top bit is set, `sq` is at least 2^(2·WIDTH−2). The operand 2^(WIDTH−1) gives exactly 2^(2·WIDTH−2).
- R8: While `opnd` stays unchanged out of reset, `sq` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset, clears the output register |
| opnd | input | WIDTH | Unsigned operand to be squared |
| sq | output | 2*WIDTH | Unsigned square of the operand |

## Verification
Reset and the loading of a fresh operand can meet on the same clock edge. The bench holds `rst_n` low while it drives the largest operand, and expects zero rather than 65025 after that edge. It then releases reset with a different operand already in place and expects exactly that operand's square on the next edge. The same bench runs all 256 operands in a single sweep, which exercises both the shifted-sum path (top bit set) and the pass-through path (top bit clear) at every level of the chain. Seeded random operands and directed boundary values are then checked against a square computed in the bench.

// File: rtl/sqr_pkg.sv
// Shared constants and helpers for the recursive squarer.
// Assumes operand widths of at least 1.
package sqr_pkg;
    // Narrowest operand served by the dedicated leaf cell.
    localparam int unsigned LEAF_W = 2;

    // Width of the square of an n-bit unsigned value.
    function automatic int unsigned sq_w(input int unsigned n);
        return 2 * n;
    endfunction
endpackage

// File: rtl/sq_leaf2.sv
// 2-bit squaring leaf: one AND gate feeding one half adder.
// Squares 0..3 to 0, 1, 4 and 9. Purely combinational.
module sq_leaf2 (
    input  logic [1:0] a,
    output logic [3:0] s
);
    logic both;
    logic ha_sum;
    logic ha_cry;

    // AND of the two operand bits.
    assign both   = a[1] & a[0];
    // Half adder on the top bit and the AND term.
    assign ha_sum = a[1] ^ both;
    assign ha_cry = a[1] & both;

    // Pack the result bits; bit 1 of any square is zero.
    assign s = {ha_cry, ha_sum, 1'b0, a[0]};
endmodule

// File: rtl/sq_stage.sv
// One level of the squarer chain for a K-bit operand.
// Receives e, the square of a[K-2:0] from the level below, and returns a².
// With the top bit set: s = (a + c) << (K-1) + e, where c = a[K-2:0].
// With the top bit clear: s = e, zero-extended.
// Assumes K >= 3. c always fits in K-1 bits, so no overflow can occur.
module sq_stage #(
    parameter int unsigned K = 3
) (
    input  logic [K-1:0]                   a,
    input  logic [sqr_pkg::sq_w(K-1)-1:0]  e,
    output logic [sqr_pkg::sq_w(K)-1:0]    s
);
    localparam int unsigned SW = sqr_pkg::sq_w(K);
    localparam int unsigned CW = K - 1;

    logic [CW-1:0] c;
    logic [K:0]    d;
    logic [SW-1:0] f;
    logic [SW-1:0] g;

    // The offset from the base is the operand with its top bit dropped.
    assign c = a[K-2:0];

    // Sum (a + c), gated to zero when the operand lies below the base.
    always_comb begin
        if (a[K-1]) begin
            d = {1'b0, a} + {2'b00, c};
        end else begin
            d = '0;
        end
    end

    // Scaling by the base is a shift of K-1 places.
    assign f = {d, {(K-1){1'b0}}};
    // Zero-extend the smaller square to the full width.
    assign g = {2'b00, e};
    // Final full-width addition.
    assign s = f + g;
endmodule

// File: rtl/rec_squarer.sv
// Multiplier-free unsigned squarer. A chain of sq_stage levels sits on a
// 2-bit leaf, and level k squares opnd[k-1:0]. An optional output register
// with a synchronous active-low reset follows the chain.
// Assumes WIDTH >= 1. WIDTH = 1 passes the operand straight through.
module rec_squarer #(
    parameter int unsigned WIDTH   = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [WIDTH-1:0]                    opnd,
    output logic [sqr_pkg::sq_w(WIDTH)-1:0]     sq
);
    localparam int unsigned PW = sqr_pkg::sq_w(WIDTH);

    logic [PW-1:0] comb_sq;

    // Choose the datapath for the configured width.
    generate
        if (WIDTH == 1) begin : g_single
            // 0*0 = 0 and 1*1 = 1: bit 0 passes through, bit 1 is zero.
            assign comb_sq = {1'b0, opnd};
        end else begin : g_chain
            for (genvar k = sqr_pkg::LEAF_W; k <= WIDTH; k++) begin : g_lvl
                logic [sqr_pkg::sq_w(k)-1:0] s;
                if (k == sqr_pkg::LEAF_W) begin : g_leaf
                    sq_leaf2 u_leaf (
                        .a (opnd[1:0]),
                        .s (s)
                    );
                end else begin : g_step
                    sq_stage #(.K(k)) u_stage (
                        .a (opnd[k-1:0]),
                        .e (g_lvl[k-1].s),
                        .s (s)
                    );
                end
            end
            assign comb_sq = g_lvl[WIDTH].s;
        end
    endgenerate

    // Optional output register.
    generate
        if (REG_OUT) begin : g_reg
            // Capture the square; reset clears it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sq <= '0;
                end else begin
                    sq <= comb_sq;
                end
            end
        end else begin : g_comb
            assign sq = comb_sq;
        end
    endgenerate
endmodule

// File: rtl/rec_squarer_chk.sv
// Property checker for rec_squarer, attached to it with a bind statement.
// The clocked checks apply when the output register is present.
module rec_squarer_chk #(
    parameter int unsigned WIDTH   = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [WIDTH-1:0]                    opnd,
    input logic [sqr_pkg::sq_w(WIDTH)-1:0]     sq
);
    localparam int unsigned PW = sqr_pkg::sq_w(WIDTH);
    localparam logic [PW-1:0] ONES  = {{WIDTH{1'b0}}, {WIDTH{1'b1}}};
    localparam logic [PW-1:0] MAXSQ = ONES * ONES;
    localparam logic [PW-1:0] FLOOR = {2'b01, {(PW-2){1'b0}}};

    generate
        if (REG_OUT) begin : g_clk
            AST_SQUARE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> sq == PW'($past(opnd)) * PW'($past(opnd))); // R1
            AST_RESET_CLEAR: assert property (@(posedge clk)
                !rst_n |=> sq == '0); // R2
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                sq <= MAXSQ); // R3
            AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (sq[0] == $past(opnd[0])) && (sq[1] == 1'b0)); // R4
            AST_SURPLUS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(opnd[WIDTH-1])) |-> sq[PW-1:PW-2] == 2'b00); // R6
            AST_DEFICIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(opnd[WIDTH-1])) |-> sq >= FLOOR); // R7
            AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && rst_n && $stable(opnd)) |=> $stable(sq)); // R8
            if (WIDTH >= 2) begin : g_leaf_chk
                AST_LEAF_MAP: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n) && ($past(opnd) < WIDTH'(4))) |->
                    sq == PW'({$past(opnd[1] & opnd[0]), $past(opnd[1] & ~opnd[0]),
                               1'b0, $past(opnd[0])})); // R5
            end
        end else begin : g_nclk
            // Unregistered variant: the output follows the operand.
            always_comb begin
                AST_COMB_MATCH: assert (sq == PW'(opnd) * PW'(opnd)); // R1
            end
        end
    endgenerate
endmodule

bind rec_squarer rec_squarer_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .opnd  (opnd),
    .sq    (sq)
);

// File: tb/sim_rec_squarer.sv
// Bench for rec_squarer: an exhaustive sweep, seeded random operands and
// directed corner cases, all checked against squares computed in the bench.
module sim_rec_squarer;
    localparam int unsigned W  = 8;
    localparam int unsigned PW = 2 * W;

    logic          clk;
    logic          rst_n;
    logic [W-1:0]  opnd;
    logic [PW-1:0] sq;

    int n_cmp;
    int n_bad;

    rec_squarer #(.WIDTH(W), .REG_OUT(1'b1)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .opnd  (opnd),
        .sq    (sq)
    );

    // 125 MHz clock.
    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [PW-1:0] ref_sq(input logic [W-1:0] v);
        logic [PW-1:0] x;
        x = PW'(v);
        return x * x;
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the next rising edge.
    task automatic apply(input logic [W-1:0] v);
        @(negedge clk);
        opnd = v;
        @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [W-1:0] rv;
        n_cmp = 0;
        n_bad = 0;
        seed  = 32'd20240611;
        void'($urandom(seed));
        rst_n = 1'b0;
        opnd  = '1;

        // R2: reset and the largest operand arrive together; reset wins.
        apply('1);
        apply('1);
        check("R2", sq, '0);

        // Release reset with a different operand already applied.
        @(negedge clk);
        rst_n = 1'b1;
        opnd  = 8'd13;
        @(posedge clk);
        #1;
        check("R2", sq, 16'd169);

        // R5: leaf values for operands 0..3.
        apply(8'd0); check("R5", sq, 16'd0);
        apply(8'd1); check("R5", sq, 16'd1);
        apply(8'd2); check("R5", sq, 16'd4);
        apply(8'd3); check("R5", sq, 16'd9);

        // R3: largest operand gives the largest square.
        apply(8'd255); check("R3", sq, 16'd65025);
        // R7: the base itself, and the 3-bit worked example 7 -> 49.
        apply(8'd128); check("R7", sq, 16'd16384);
        apply(8'd7);   check("R1", sq, 16'd49);
        apply(8'd127); check("R6", sq, 16'd16129);

        // R8: the output holds while the operand is held.
        apply(8'd200);
        check("R1", sq, 16'd40000);
        @(posedge clk); #1; check("R8", sq, 16'd40000);
        @(posedge clk); #1; check("R8", sq, 16'd40000);

        // R1: exhaustive sweep, with R4, R6 and R7 views of each result.
        for (int i = 0; i < (1 << W); i++) begin
            apply(W'(i));
            check("R1", sq, ref_sq(W'(i)));
            check("R4", PW'(sq[1:0]), PW'({1'b0, opnd[0]}));
            if (opnd[W-1]) begin
                check("R7", PW'(sq >= PW'(1) << (PW - 2)), PW'(1));
            end else begin
                check("R6", sq, ref_sq({1'b0, opnd[W-2:0]}));
            end
        end

        // R1: seeded random operands.
        for (int j = 0; j < 400; j++) begin
            rv = W'($urandom);
            apply(rv);
            check("R1", sq, ref_sq(rv));
            check("R3", PW'(sq <= 16'd65025), PW'(1));
        end

        // R2: reset in the middle of operation.
        @(negedge clk);
        rst_n = 1'b0;
        opnd  = 8'd99;
        @(posedge clk); #1;
        check("R2", sq, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", sq, 16'd9801);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule